// File: doc/BRIEF.md
# Scaled Compare Buffer Register Bank

This block holds the staging (buffer) values for the compare channels of a timer/PWM peripheral. Software reaches each 16-bit buffer over an 8-bit register bus. A write to the low byte goes only into a shared holding latch. A write to the high byte joins that latch with the new high byte, so the whole 16-bit word arrives at once. The joined word is stored in the selected buffer one clock later. On the way it can be rescaled.

When scaling is enabled, the written word is taken as an unsigned fraction with one integer bit and fifteen fraction bits. It is multiplied by the timer period. In amplitude mode it is instead multiplied by an amplitude value, and an offset is then added. The result saturates at the 16-bit maximum. Each stored result sets the valid flag of its channel. An update event moves every valid buffer into its live compare register and clears the flag.

Top module: `cmpBufBank`

## Requirements
- R1: After reset, all four buffers read back 0x00 on both bytes, all compare outputs are 0 and all valid flags are 0.
- R2: Channel n's buffer low byte is at bus address 0x38 + 2n and its high byte at 0x39 + 2n. Both read back the stored value. A read outside 0x38..0x3F returns 0x00, and a write outside that window changes no buffer.
- R3: A low-byte write changes no buffer. It only loads the holding latch, which becomes bits 7:0 of the word formed by the next high-byte write, whatever channel that write addresses.
- R4: With scaling off, a high-byte write stores {high byte, latch} unchanged into that channel's buffer on the second rising edge after the write is presented (one clock after the write edge).
- R5: With scaling on and amplitude mode off, the stored value is min((word × period) >> 15, 0xFFFF).
- R6: With scaling on and amplitude mode on, the stored value is min(((word × amplitude) >> 15) + offset, 0xFFFF).
- R7: A channel's valid flag rises only when a result is stored into that channel's buffer.
- R8: On an update event, every channel whose valid flag is set copies its buffer into its compare output and clears its flag. Channels without the flag keep their compare output. With no update event, no compare output changes.
- R9: If an update event and a store hit the same channel in the same clock, the compare output takes the buffer value held before the store, the new value lands in the buffer, and that channel's valid flag stays set.
- R10: The scale-enable and amplitude-mode inputs are sampled in the high-byte write cycle. Period, amplitude and offset are sampled in the store cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Bus byte write strobe |
| busAddr | input | 8 | Bus byte address |
| busWrData | input | 8 | Bus write byte |
| busRdData | output | 8 | Bus read byte (combinational from busAddr) |
| scaleEn | input | 1 | Treat written words as Q1.15 fractions and scale them |
| ampMode | input | 1 | Scale by amplitude plus offset instead of by period |
| periodVal | input | 16 | Timer period |
| ampVal | input | 16 | Amplitude multiplier |
| offsetVal | input | 16 | Offset added in amplitude mode |
| updateEv | input | 1 | Update event: move valid buffers to compare outputs |
| bufValid | output | 4 | Per-channel buffer-valid flags |
| cmpFlat | output | 64 | Compare outputs, channel n at bits 16n+15:16n |

## Verification
The store of a scaled result and the update event can fall on the same clock edge and hit the same channel. The bench provokes this by writing a channel twice without an update in between, so its flag is already set. It then raises the update event exactly in the cycle where the second store lands. It judges the outcome at the ports: the compare output must show the first value, the buffer must read back the second, and the flag must stay high while every other channel's flag clears.

// File: rtl/cmpBufPkg.sv
package cmpBufPkg;

  // Channel select width carried in the strobe bundle (up to 16 channels).
  localparam int CH_SEL_W = 4;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic                loWr;      // low byte write into holding latch
    logic                hiWr;      // high byte write: capture joined word
    logic [CH_SEL_W-1:0] wrChan;    // channel addressed by current write
    logic                storeVld;  // pending word is stored this cycle
    logic [CH_SEL_W-1:0] storeChan; // channel receiving the store
  } bufStrobes_t;

endpackage

// File: rtl/cmpBufCtrl.sv
module cmpBufCtrl
  import cmpBufPkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h38
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic [ADDR_W-1:0]   busAddr,
  output bufStrobes_t         strb,
  output logic                rdHit,
  output logic [CH_SEL_W-1:0] rdChan,
  output logic                rdHiByte
);

  localparam int SPAN = 2 * NUM_CH;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(SPAN);

  logic [ADDR_W-1:0]   relAddr;
  logic                inWindow;
  logic [CH_SEL_W-1:0] decChan;
  logic                storeVldQ;
  logic [CH_SEL_W-1:0] storeChanQ;

  // Address decode: even offsets are low bytes, odd offsets high bytes.
  assign relAddr  = busAddr - BASE_A;
  assign inWindow = (busAddr >= BASE_A) && (relAddr < SPAN_A);
  assign decChan  = CH_SEL_W'(relAddr >> 1);

  assign rdHit    = inWindow;
  assign rdChan   = decChan;
  assign rdHiByte = relAddr[0];

  // One-stage pipeline: the store follows the high-byte write by one clock.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      storeVldQ  <= 1'b0;
      storeChanQ <= '0;
    end else begin
      storeVldQ  <= busWrEn && inWindow && relAddr[0];
      storeChanQ <= decChan;
    end
  end

  always_comb begin
    strb.loWr      = busWrEn && inWindow && !relAddr[0];
    strb.hiWr      = busWrEn && inWindow && relAddr[0];
    strb.wrChan    = decChan;
    strb.storeVld  = storeVldQ;
    strb.storeChan = storeChanQ;
  end

  AST_STORE_FOLLOWS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    strb.hiWr |=> (strb.storeVld && strb.storeChan == $past(strb.wrChan))); // R4

  AST_NO_STRAY_STORE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.hiWr |=> !strb.storeVld); // R4

endmodule

// File: rtl/cmpBufScaler.sv
module cmpBufScaler #(
  parameter int DATA_W    = 16,
  parameter int FRAC_BITS = 15
) (
  input  logic [DATA_W-1:0] rawWord,
  input  logic              scaleOn,
  input  logic              ampOn,
  input  logic [DATA_W-1:0] periodVal,
  input  logic [DATA_W-1:0] ampVal,
  input  logic [DATA_W-1:0] offsetVal,
  output logic [DATA_W-1:0] result
);

  localparam int PROD_W = 2 * DATA_W;

  logic [PROD_W-1:0] multiplier;
  logic [PROD_W-1:0] product;
  logic [PROD_W-1:0] shifted;
  logic [PROD_W:0]   summed;
  logic              overRange;

  // Fixed-point multiply, drop fraction bits, optional offset, saturate.
  always_comb begin
    multiplier = ampOn ? PROD_W'(ampVal) : PROD_W'(periodVal);
    product    = PROD_W'(rawWord) * multiplier;
    shifted    = product >> FRAC_BITS;
    summed     = {1'b0, shifted} + (ampOn ? (PROD_W + 1)'(offsetVal) : '0);
    overRange  = |summed[PROD_W:DATA_W];
    if (!scaleOn) begin
      result = rawWord;
    end else if (overRange) begin
      result = '1;
    end else begin
      result = summed[DATA_W-1:0];
    end
  end

endmodule

// File: rtl/cmpBufDatapath.sv
module cmpBufDatapath
  import cmpBufPkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int BUS_W     = 8,
  parameter int FRAC_BITS = 15
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  bufStrobes_t                strb,
  input  logic [BUS_W-1:0]           busWrData,
  input  logic                       rdHit,
  input  logic [CH_SEL_W-1:0]        rdChan,
  input  logic                       rdHiByte,
  output logic [BUS_W-1:0]           busRdData,
  input  logic                       scaleEn,
  input  logic                       ampMode,
  input  logic [2*BUS_W-1:0]         periodVal,
  input  logic [2*BUS_W-1:0]         ampVal,
  input  logic [2*BUS_W-1:0]         offsetVal,
  input  logic                       updateEv,
  output logic [NUM_CH-1:0]          bufValid,
  output logic [NUM_CH*2*BUS_W-1:0]  cmpFlat
);

  localparam int DATA_W = 2 * BUS_W;
  localparam logic [DATA_W-1:0] UNITY = DATA_W'(1) << FRAC_BITS;

  logic [BUS_W-1:0]  holdLow;
  logic [DATA_W-1:0] pendRaw;
  logic              pendScale;
  logic              pendAmp;
  logic [DATA_W-1:0] scaled;
  logic [DATA_W-1:0] bufArr [NUM_CH];
  logic [DATA_W-1:0] cmpArr [NUM_CH];
  logic [DATA_W-1:0] rdWord;

  // Holding latch and the captured word with its mode bits.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdLow   <= '0;
      pendRaw   <= '0;
      pendScale <= 1'b0;
      pendAmp   <= 1'b0;
    end else begin
      if (strb.loWr) begin
        holdLow <= busWrData;
      end
      if (strb.hiWr) begin
        pendRaw   <= {busWrData, holdLow};
        pendScale <= scaleEn;
        pendAmp   <= ampMode;
      end
    end
  end

  cmpBufScaler #(
    .DATA_W    (DATA_W),
    .FRAC_BITS (FRAC_BITS)
  ) uScaler (
    .rawWord   (pendRaw),
    .scaleOn   (pendScale),
    .ampOn     (pendAmp),
    .periodVal (periodVal),
    .ampVal    (ampVal),
    .offsetVal (offsetVal),
    .result    (scaled)
  );

  // Per-channel buffer, valid flag and compare register.
  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    logic storeHere;
    assign storeHere = strb.storeVld && (strb.storeChan == CH_SEL_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        bufArr[g]   <= '0;
        cmpArr[g]   <= '0;
        bufValid[g] <= 1'b0;
      end else begin
        if (updateEv && bufValid[g]) begin
          cmpArr[g] <= bufArr[g];
        end
        if (storeHere) begin
          bufArr[g] <= scaled;
        end
        bufValid[g] <= storeHere || (bufValid[g] && !updateEv);
      end
    end

    assign cmpFlat[g*DATA_W +: DATA_W] = cmpArr[g];
  end

  // Byte read-back mux.
  always_comb begin
    rdWord = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rdChan == CH_SEL_W'(c)) begin
        rdWord = bufArr[c];
      end
    end
    if (!rdHit) begin
      busRdData = '0;
    end else if (rdHiByte) begin
      busRdData = rdWord[DATA_W-1:BUS_W];
    end else begin
      busRdData = rdWord[BUS_W-1:0];
    end
  end

  AST_VALID_RISE_NEEDS_STORE: assert property (@(posedge clk) disable iff (!rstN)
    (|(bufValid & ~$past(bufValid))) |-> $past(strb.storeVld)); // R7

  AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !updateEv |=> $stable(cmpFlat)); // R8

  AST_UPDATE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (updateEv && !strb.storeVld) |=> (bufValid == '0)); // R8

  AST_COLLIDE_ONE_LEFT: assert property (@(posedge clk) disable iff (!rstN)
    (updateEv && strb.storeVld) |=> ($countones(bufValid) == 1)); // R9

  AST_PERIOD_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (strb.storeVld && pendScale && !pendAmp && pendRaw <= UNITY)
      |-> (scaled <= periodVal)); // R5

  AST_AMP_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    (strb.storeVld && pendScale && pendAmp) |-> (scaled >= offsetVal)); // R6

endmodule

// File: rtl/cmpBufBank.sv
module cmpBufBank
  import cmpBufPkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int BUS_W     = 8,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h38,
  parameter int FRAC_BITS = 15
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      busWrEn,
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic [BUS_W-1:0]          busWrData,
  output logic [BUS_W-1:0]          busRdData,
  input  logic                      scaleEn,
  input  logic                      ampMode,
  input  logic [2*BUS_W-1:0]        periodVal,
  input  logic [2*BUS_W-1:0]        ampVal,
  input  logic [2*BUS_W-1:0]        offsetVal,
  input  logic                      updateEv,
  output logic [NUM_CH-1:0]         bufValid,
  output logic [NUM_CH*2*BUS_W-1:0] cmpFlat
);

  bufStrobes_t         strb;
  logic                rdHit;
  logic [CH_SEL_W-1:0] rdChan;
  logic                rdHiByte;

  cmpBufCtrl #(
    .NUM_CH    (NUM_CH),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .busWrEn  (busWrEn),
    .busAddr  (busAddr),
    .strb     (strb),
    .rdHit    (rdHit),
    .rdChan   (rdChan),
    .rdHiByte (rdHiByte)
  );

  cmpBufDatapath #(
    .NUM_CH    (NUM_CH),
    .BUS_W     (BUS_W),
    .FRAC_BITS (FRAC_BITS)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busWrData (busWrData),
    .rdHit     (rdHit),
    .rdChan    (rdChan),
    .rdHiByte  (rdHiByte),
    .busRdData (busRdData),
    .scaleEn   (scaleEn),
    .ampMode   (ampMode),
    .periodVal (periodVal),
    .ampVal    (ampVal),
    .offsetVal (offsetVal),
    .updateEv  (updateEv),
    .bufValid  (bufValid),
    .cmpFlat   (cmpFlat)
  );

endmodule

// File: tb/tb_cmpBufBank.sv
module tb_cmpBufBank;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [7:0]  busWrData = 8'h00;
  logic [7:0]  busRdData;
  logic        scaleEn = 1'b0;
  logic        ampMode = 1'b0;
  logic [15:0] periodVal = 16'd0;
  logic [15:0] ampVal = 16'd0;
  logic [15:0] offsetVal = 16'd0;
  logic        updateEv = 1'b0;
  logic [3:0]  bufValid;
  logic [63:0] cmpFlat;

  int errCnt = 0;
  int chkCnt = 0;
  bit finished = 1'b0;

  typedef struct { int ch; logic [15:0] val; } expItem_t;
  expItem_t sbQ[$];
  logic [15:0] shadow [4];
  logic [15:0] expCmp [4];
  logic [3:0]  prevValid = 4'b0;

  always #5 clk = ~clk;

  cmpBufBank dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .scaleEn(scaleEn),
    .ampMode(ampMode), .periodVal(periodVal), .ampVal(ampVal),
    .offsetVal(offsetVal), .updateEv(updateEv), .bufValid(bufValid),
    .cmpFlat(cmpFlat)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expScale(input logic [15:0] raw, input bit en,
      input bit amp, input logic [15:0] per, input logic [15:0] av, input logic [15:0] off);
    longint p;
    if (!en) return raw;
    p = longint'(raw) * longint'(amp ? av : per);
    p = p >>> 15;
    if (amp) p = p + longint'(off);
    return (p > 65535) ? 16'hFFFF : p[15:0];
  endfunction

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic readWord(input int ch, output logic [15:0] w);
    @(negedge clk);
    busAddr = 8'(8'h38 + 2 * ch); #1; w[7:0] = busRdData;
    @(negedge clk);
    busAddr = 8'(8'h39 + 2 * ch); #1; w[15:8] = busRdData;
  endtask

  // Driver: write both bytes and push the expected stored value.
  task automatic writeWord(input int ch, input logic [15:0] raw, input logic [15:0] exp);
    expItem_t it;
    it.ch = ch; it.val = exp;
    sbQ.push_back(it);
    busWrite(8'(8'h38 + 2 * ch), raw[7:0]);
    busWrite(8'(8'h39 + 2 * ch), raw[15:8]);
    repeat (2) @(negedge clk);
  endtask

  task automatic checkBuf(input string req, input int ch);
    logic [15:0] w;
    readWord(ch, w);
    chk(req, 32'(w), 32'(shadow[ch]));
  endtask

  task automatic pulseUpdate(input string req);
    @(negedge clk);
    for (int c = 0; c < 4; c++) if (bufValid[c]) expCmp[c] = shadow[c];
    updateEv = 1'b1;
    @(negedge clk);
    updateEv = 1'b0;
    for (int c = 0; c < 4; c++) chk(req, 32'(cmpFlat[c*16 +: 16]), 32'(expCmp[c]));
    chk(req, 32'(bufValid), 32'h0);
  endtask

  // Monitor: a rising valid flag pops the scoreboard and records the value.
  always @(negedge clk) begin
    if (rstN) begin
      for (int c = 0; c < 4; c++) begin
        if (bufValid[c] && !prevValid[c]) begin
          chkCnt++;
          if (sbQ.size() == 0) begin
            errCnt++;
            $display("FAIL R7: actual=valid rise ch%0d expected=no store pending", c);
          end else begin
            expItem_t it;
            it = sbQ.pop_front();
            if (it.ch != c) begin
              errCnt++;
              $display("FAIL R7: actual=ch%0d expected=ch%0d", c, it.ch);
            end
            shadow[c] = it.val;
          end
        end
      end
    end
    prevValid = bufValid;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errCnt++;
      chkCnt++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    for (int c = 0; c < 4; c++) begin shadow[c] = 16'h0; expCmp[c] = 16'h0; end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 valid", 32'(bufValid), 32'h0);
    chk("R1 cmp", cmpFlat[31:0], 32'h0);
    chk("R1 cmp", cmpFlat[63:32], 32'h0);
    for (int c = 0; c < 4; c++) checkBuf("R1 buf", c);

    // R4 / R2 plain stores
    writeWord(1, 16'h1234, 16'h1234);
    checkBuf("R4 ch1 plain", 1);
    writeWord(3, 16'hBEEF, 16'hBEEF);
    checkBuf("R2 ch3 bytes", 3);

    // R3 low byte alone changes nothing; latch feeds next high write
    busWrite(8'h3C, 8'h55);
    repeat (2) @(negedge clk);
    checkBuf("R3 low only", 2);
    chk("R3 no valid", 32'(bufValid[2]), 32'h0);
    sbQ.push_back('{2, 16'hA055});
    busWrite(8'h3D, 8'hA0);
    repeat (2) @(negedge clk);
    checkBuf("R3 latch joined", 2);

    // R2 out-of-window writes and reads
    busWrite(8'h40, 8'hFF);
    busWrite(8'h37, 8'hFF);
    repeat (2) @(negedge clk);
    for (int c = 0; c < 4; c++) checkBuf("R2 outside write", c);
    @(negedge clk); busAddr = 8'h40; #1;
    chk("R2 outside read", 32'(busRdData), 32'h0);

    // R8 update moves valid buffers, then an idle update changes nothing
    pulseUpdate("R8 update");
    pulseUpdate("R8 idle update");

    // R5 period scaling
    scaleEn = 1'b1; periodVal = 16'd1000;
    writeWord(0, 16'h4000, expScale(16'h4000, 1, 0, 16'd1000, 0, 0));
    checkBuf("R5 half period", 0);
    chk("R5 value", 32'(shadow[0]), 32'd500);
    writeWord(1, 16'h8000, 16'd1000);
    checkBuf("R5 unity", 1);
    periodVal = 16'hC000;
    writeWord(2, 16'hFFFF, expScale(16'hFFFF, 1, 0, 16'hC000, 0, 0));
    checkBuf("R5 saturate", 2);
    chk("R5 sat value", 32'(shadow[2]), 32'hFFFF);
    pulseUpdate("R8 scaled update");

    // R6 amplitude mode
    ampMode = 1'b1; ampVal = 16'd2000; offsetVal = 16'd100;
    writeWord(3, 16'h4000, 16'd1100);
    checkBuf("R6 amp offset", 3);
    ampVal = 16'hFFFF; offsetVal = 16'h0010;
    writeWord(0, 16'hFFFF, 16'hFFFF);
    checkBuf("R6 saturate", 0);
    ampMode = 1'b0; periodVal = 16'd1000;

    // R10 mode bits taken at the high-byte write
    sbQ.push_back('{1, expScale(16'h2000, 1, 0, 16'd1000, 0, 0)});
    busWrite(8'h3A, 8'h00);
    busWrite(8'h3B, 8'h20);
    scaleEn = 1'b0;
    repeat (2) @(negedge clk);
    checkBuf("R10 mode sampled", 1);
    scaleEn = 1'b1;
    pulseUpdate("R8 before collision");

    // R9 store and update collide on channel 2
    scaleEn = 1'b0;
    writeWord(2, 16'h1111, 16'h1111);
    busWrite(8'h3C, 8'h22);
    busWrite(8'h3D, 8'h22);
    updateEv = 1'b1;
    @(negedge clk);
    updateEv = 1'b0;
    shadow[2] = 16'h2222;
    chk("R9 cmp old", 32'(cmpFlat[47:32]), 32'h1111);
    chk("R9 valid kept", 32'(bufValid), 32'h4);
    checkBuf("R9 buf new", 2);
    chk("R7 queue drained", 32'(sbQ.size()), 32'h0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule